// File: doc/BRIEF.md
# Indexed Page Permission Remapper

This block takes the place of the fixed decoder that turns a page-table entry's permission bits into access rights. The four permission-related bits of a translated entry (two access-permission bits and the privileged and unprivileged execute-never bits) are not decoded as rights. They are joined into a 4-bit index. The index selects a 3-bit {read, write, execute} entry in a programmable table. There is one table for kernel mode and one for user mode, so a page can carry different rights in each mode. In user mode a third programmable register with the same layout acts as a restriction mask. It is ANDed with the user-table entry, so it can remove rights but never add them.

Because the rights sit in registers and not in the page tables, one register write changes the effective rights of every page whose bits form that index. No page-table walk is needed. The lookup is purely combinational. An access-type input (load, store or fetch) is checked against the resulting grants and gives a single fault output.

The lookup path carries no handshake because it is combinational, so it has no back-pressure. The configuration write port has no ready signal: a write is always accepted on the rising edge where the write enable is high. All three registers reset to zero, and zero denies every access.

Top module: `perm_remap`

## Requirements
- R1: After reset all three registers read back as zero, every grant output is 0 and `fault` is 1 for every access type.
- R2: The index is {pte_ap1, pte_ap0, pte_pxn, pte_uxn}, with pte_ap1 as the most significant bit. Entry i of a register occupies bits [3i+2:3i], ordered {R, W, X} with R in bit 3i+2.
- R3: With priv_kernel=1 the grants equal the kernel-table entry at the index. The user mask has no effect in this mode.
- R4: With priv_kernel=0 the grants equal the user-table entry ANDed bitwise with the user-mask entry at the same index, so a grant is never wider than the mask entry.
- R5: cfg_wsel selects the register written: 0 = kernel table, 1 = user table, 2 = user mask. A write with cfg_wsel=3 changes no register.
- R6: A write accepted on a rising edge affects lookups from that edge on and not before it. Without cfg_we no register changes.
- R7: acc_type 0 = load checks R, 1 = store checks W, 2 = fetch checks X. `fault` is 1 exactly when the checked grant is 0. acc_type 3 is reserved and always faults.
- R8: cfg_rdata returns the register selected by cfg_rsel (same codes as R5) combinationally. cfg_rsel=3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pte_ap1 | input | 1 | Access-permission bit 1 of the entry (index MSB) |
| pte_ap0 | input | 1 | Access-permission bit 0 of the entry |
| pte_pxn | input | 1 | Privileged execute-never bit of the entry |
| pte_uxn | input | 1 | Unprivileged execute-never bit of the entry (index LSB) |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| grant_r | output | 1 | Effective read right |
| grant_w | output | 1 | Effective write right |
| grant_x | output | 1 | Effective execute right |
| fault | output | 1 | Requested access is not granted |
| cfg_we | input | 1 | Register write enable |
| cfg_wsel | input | 2 | Register to write |
| cfg_wdata | input | 48 | Write data, 16 entries of 3 bits |
| cfg_rsel | input | 2 | Register to read back |
| cfg_rdata | output | 48 | Read-back data |

## Verification
The grants, the fault and the read-back data are combinational, so they are due in the same cycle as the lookup or select inputs. The bench drives inputs on the falling edge and samples a fraction of a nanosecond later, well before the next rising edge. A register write takes effect at the rising edge that captures it. The bench confirms that a lookup driven together with the write still shows the old rights before that edge and the new rights just after it. It updates its own reference copy of the registers only after the capturing edge.

// File: rtl/perm_remap_pkg.sv
package perm_remap_pkg;
  localparam int PERM_W = 3;
  localparam int NUM_REGS = 3;

  typedef enum logic [1:0] {
    SEL_KERN = 2'd0,
    SEL_USER = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/perm_regfile.sv
module perm_regfile
  import perm_remap_pkg::*;
#(
  parameter int TBL_W = 48,
  parameter int NREG  = NUM_REGS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [1:0]                 wsel,
  input  logic [TBL_W-1:0]           wdata,
  input  logic [1:0]                 rsel,
  output logic [TBL_W-1:0]           rdata,
  output logic [NREG-1:0][TBL_W-1:0] regs_o
);
  // one storage register per table; a select code with no register is dropped
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (we && (wsel == 2'(g))) begin
        regs_o[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rsel == 2'(i)) rdata = regs_o[i];
    end
  end
endmodule

// File: rtl/perm_entry_sel.sv
module perm_entry_sel
  import perm_remap_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TBL_W = (1 << IDX_W) * PERM_W
) (
  input  logic [TBL_W-1:0] tbl,
  input  logic [IDX_W-1:0] idx,
  output perm_t            ent
);
  assign ent = perm_t'(tbl[int'(idx) * PERM_W +: PERM_W]);
endmodule

// File: rtl/perm_fault_gen.sv
module perm_fault_gen
  import perm_remap_pkg::*;
(
  input  perm_t      eff,
  input  logic [1:0] acc,
  output logic       fault
);
  always_comb begin
    unique case (acc_kind_e'(acc))
      ACC_LOAD:  fault = ~eff.r;
      ACC_STORE: fault = ~eff.w;
      ACC_FETCH: fault = ~eff.x;
      default:   fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/perm_remap.sv
module perm_remap
  import perm_remap_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int NENT = 1 << IDX_W,
  localparam int TBL_W = NENT * PERM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pte_ap1,
  input  logic             pte_ap0,
  input  logic             pte_pxn,
  input  logic             pte_uxn,
  input  logic             priv_kernel,
  input  logic [1:0]       acc_type,
  output logic             grant_r,
  output logic             grant_w,
  output logic             grant_x,
  output logic             fault,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_wsel,
  input  logic [TBL_W-1:0] cfg_wdata,
  input  logic [1:0]       cfg_rsel,
  output logic [TBL_W-1:0] cfg_rdata
);
  logic [NUM_REGS-1:0][TBL_W-1:0] tbl_q;
  logic [IDX_W-1:0]               idx;
  perm_t                          ent [NUM_REGS];
  perm_t                          eff;

  // permission bits form the index, most significant first
  assign idx = IDX_W'({pte_ap1, pte_ap0, pte_pxn, pte_uxn});

  perm_regfile #(.TBL_W(TBL_W), .NREG(NUM_REGS)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wsel  (cfg_wsel),
    .wdata (cfg_wdata),
    .rsel  (cfg_rsel),
    .rdata (cfg_rdata),
    .regs_o(tbl_q)
  );

  for (genvar t = 0; t < NUM_REGS; t++) begin : g_sel
    perm_entry_sel #(.IDX_W(IDX_W), .TBL_W(TBL_W)) u_sel (
      .tbl(tbl_q[t]),
      .idx(idx),
      .ent(ent[t])
    );
  end

  // kernel takes its table as is; user is narrowed by the mask
  always_comb begin
    if (priv_kernel) eff = ent[SEL_KERN];
    else             eff = perm_t'(ent[SEL_USER] & ent[SEL_MASK]);
  end

  assign grant_r = eff.r;
  assign grant_w = eff.w;
  assign grant_x = eff.x;

  perm_fault_gen u_fault (
    .eff  (eff),
    .acc  (acc_type),
    .fault(fault)
  );
endmodule

// File: rtl/perm_remap_chk.sv
module perm_remap_chk #(
  parameter int IDX_W = 4,
  localparam int TBL_W = (1 << IDX_W) * 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pte_ap1,
  input logic                 pte_ap0,
  input logic                 pte_pxn,
  input logic                 pte_uxn,
  input logic                 priv_kernel,
  input logic [1:0]           acc_type,
  input logic                 grant_r,
  input logic                 grant_w,
  input logic                 grant_x,
  input logic                 fault,
  input logic                 cfg_we,
  input logic [1:0]           cfg_wsel,
  input logic [TBL_W-1:0]     cfg_wdata,
  input logic [2:0][TBL_W-1:0] tbl_q
);
  logic [IDX_W-1:0] idx;
  logic [2:0]       grant;
  logic [2:0]       kent;
  logic [2:0]       ment;

  assign idx   = IDX_W'({pte_ap1, pte_ap0, pte_pxn, pte_uxn});
  assign grant = {grant_r, grant_w, grant_x};
  assign kent  = tbl_q[0][int'(idx) * 3 +: 3];
  assign ment  = tbl_q[2][int'(idx) * 3 +: 3];

  // R5
  kern_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wsel == 2'd0) |=> (tbl_q[0] == $past(cfg_wdata)));

  // R5
  bad_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wsel == 2'd3) |=> $stable(tbl_q));

  // R6
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(tbl_q));

  // R3
  kern_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_kernel |-> (grant == kent));

  // R4
  user_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_kernel |-> ((grant & ~ment) == 3'b000));

  // R7
  fetch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == 2'd2) |-> (fault == !grant_x));

  // R7
  rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == 2'd3) |-> fault);
endmodule

bind perm_remap perm_remap_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pte_ap1    (pte_ap1),
  .pte_ap0    (pte_ap0),
  .pte_pxn    (pte_pxn),
  .pte_uxn    (pte_uxn),
  .priv_kernel(priv_kernel),
  .acc_type   (acc_type),
  .grant_r    (grant_r),
  .grant_w    (grant_w),
  .grant_x    (grant_x),
  .fault      (fault),
  .cfg_we     (cfg_we),
  .cfg_wsel   (cfg_wsel),
  .cfg_wdata  (cfg_wdata),
  .tbl_q      (tbl_q)
);

// File: tb/tb_perm_remap.sv
`timescale 1ns/100ps
module tb_perm_remap;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pte_ap1 = 0, pte_ap0 = 0, pte_pxn = 0, pte_uxn = 0;
  logic        priv_kernel = 0;
  logic [1:0]  acc_type = 0;
  logic        grant_r, grant_w, grant_x, fault;
  logic        cfg_we = 0;
  logic [1:0]  cfg_wsel = 0;
  logic [47:0] cfg_wdata = 0;
  logic [1:0]  cfg_rsel = 0;
  logic [47:0] cfg_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [47:0] m_tbl [3];

  perm_remap dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_grant(bit kern, int idx);
    if (kern) return m_tbl[0][idx*3 +: 3];
    return m_tbl[1][idx*3 +: 3] & m_tbl[2][idx*3 +: 3];
  endfunction

  function automatic logic exp_fault(logic [2:0] g, int a);
    case (a)
      0: return ~g[2];
      1: return ~g[1];
      2: return ~g[0];
      default: return 1'b1;
    endcase
  endfunction

  task automatic set_idx(int idx);
    {pte_ap1, pte_ap0, pte_pxn, pte_uxn} = 4'(idx);
  endtask

  // drive a lookup after a falling edge and check grants and every access type
  task automatic probe(bit kern, int idx, string req);
    logic [2:0] g;
    @(negedge clk);
    priv_kernel = kern;
    set_idx(idx);
    g = exp_grant(kern, idx);
    for (int a = 0; a < 4; a++) begin
      acc_type = 2'(a);
      #0.2;
      if (a == 0) chk(req, 48'({grant_r, grant_w, grant_x}), 48'(g));
      chk({req, " R7"}, 48'(fault), 48'(exp_fault(g, a)));
    end
  endtask

  task automatic wr(int sel, logic [47:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_wsel = 2'(sel); cfg_wdata = d;
    @(posedge clk);
    if (sel < 3) m_tbl[sel] = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic readback(string req);
    for (int s = 0; s < 4; s++) begin
      cfg_rsel = 2'(s);
      #0.2;
      chk(req, cfg_rdata, (s < 3) ? m_tbl[s] : 48'h0);
    end
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    for (int i = 0; i < 3; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    @(negedge clk);
    readback("R1 R8");
    probe(1, 7, "R1");
    probe(0, 15, "R1");

    // R2: only entry 5 (ap0=1, uxn=1) grants read in kernel
    wr(0, 48'h0 | (48'b100 << 15));
    probe(1, 5, "R2 R3");
    probe(1, 10, "R2");
    probe(1, 4, "R2");

    // R4: user table open, mask lets only entry 3 through as read-write
    wr(1, {48{1'b1}});
    wr(2, 48'b110 << 9);
    probe(0, 3, "R4");
    probe(0, 4, "R4");
    // R3: mask ignored in kernel mode
    probe(1, 5, "R3");

    // R5: select 3 changes nothing
    wr(3, 48'hfff_ffff_ffff);
    readback("R5 R8");
    probe(0, 3, "R5");

    // R6: lookup sees old rights until the capturing edge
    @(negedge clk);
    priv_kernel = 1; set_idx(9); acc_type = 0;
    cfg_we = 1; cfg_wsel = 0; cfg_wdata = 48'b111 << 27;
    #0.5;
    chk("R6 before edge", 48'({grant_r, grant_w, grant_x}), 48'(exp_grant(1, 9)));
    @(posedge clk);
    m_tbl[0] = 48'b111 << 27;
    #0.5;
    chk("R6 after edge", 48'({grant_r, grant_w, grant_x}), 48'b111);
    @(negedge clk);
    cfg_we = 0;
    readback("R6 R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0)
        wr($urandom_range(0, 3), {16'($urandom), $urandom});
      probe(1'($urandom), $urandom_range(0, 15), "R3 R4 random");
      if (n % 50 == 0) readback("R5 R8 random");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule